// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag and state side of a set-associative cache. For every way of every set it stores a line address, a two-bit access-permission state and a lock owner field, and it keeps a per-set least-recently-used order. A protocol controller sends it one operation at a time on a valid/ready request channel. Each operation names a line-aligned address. The block answers on a valid/ready response channel with a result bit, a way number, a permission value, a line address and an error flag.

The operations cover the whole life of a line. A request can check access rights for a load, store or instruction fetch. It can test presence or look up an address without regard to permission, and it can ask whether the set has room. It can allocate or release a line, change a line's permission, or ask which line the replacement order would evict. It can set, clear or test a per-line lock that holds the context of an atomic reservation, and it can mark a line most recently used. Data storage lives elsewhere.

Only one operation is in flight at a time. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response appears on the next cycle. The response stays on the port until `resp_ready` is high. While a response waits, `req_ready` is low, so back-pressure on the response side stalls the request side at once.

Top module: `tagdir_top`

## Requirements
- R1: After reset every way is empty with permission NotPresent, `resp_valid` is low and `req_ready` is high. A presence test (op 1) returns 0 and an availability test (op 2) returns 1 for any address.
- R2: A request is accepted when `req_valid` and `req_ready` are both high, and exactly one response follows on the next cycle. The response holds its values until `resp_ready` is high. `req_ready` is low while an unaccepted response is pending.
- R3: The set is selected by address bits [START_BIT+SET_W-1:START_BIT], where SET_W = log2(NUM_SETS). The same upper address bits in different sets name different lines.
- R4: Presence (op 1) is true only if a way in the set holds the address with a permission other than NotPresent. The raw lookup (op 11) matches on address alone in an occupied way and reports that way and its stored permission. Permission codes are NotPresent=0, Invalid=1, ReadOnly=2, ReadWrite=3.
- R5: The access check (op 0, request type load=0, store=1, fetch=2) succeeds on a ReadWrite line for any type. On a ReadOnly line it succeeds only for load or fetch. It fails on Invalid and on a miss. `resp_perm` reports the line's permission.
- R6: A presence match on the access check makes that way most recently used even when the permission check fails.
- R7: The availability test (op 2) returns 1 if any way of the set is empty, is NotPresent, or already holds the address.
- R8: Allocate (op 3) writes the lowest-numbered way that is empty or NotPresent. It sets the permission to Invalid and the lock to no-owner (all ones), makes the way most recently used, and reports the way with result 1.
- R9: Deallocate (op 4) of a present line empties its way, so a later presence test misses.
- R10: The victim probe (op 5) on a set with no available way returns the least recently used way and the address it stores.
- R11: Lock (op 6) stores `req_ctx` in a present line and unlock (op 7) stores all ones. Lock test (op 8) returns 1 only when the stored value equals `req_ctx`.
- R12: Set-MRU (op 9) makes a matching line most recently used and changes nothing on a miss. Set-permission (op 10) writes `req_perm` into a present line.
- R13: An illegal operation returns `resp_err`=1 and result 0, and it changes no state. The illegal cases are allocate of a present address or into a full set, deallocate, lock, unlock, lock test or set-permission of an absent line, probe of a set with room, and op codes 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 4 | Operation code |
| req_type | input | 2 | Access type for op 0 |
| req_addr | input | ADDR_W | Line-aligned address |
| req_ctx | input | CTX_W | Context for lock operations |
| req_perm | input | 2 | New permission for op 10 |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Operation result bit |
| resp_way | output | log2(WAYS) | Way matched, filled or chosen |
| resp_perm | output | 2 | Permission of that way |
| resp_addr | output | ADDR_W | Victim address for a probe |
| resp_err | output | 1 | Illegal operation, state untouched |

## Verification
The bench fills one set and walks its replacement order through allocations, granted and refused accesses, and set-MRU hits and misses. A design that skipped the touch on a refused access, or that touched on a set-MRU miss, would name the wrong victim. It downgrades a line to NotPresent and frees another way, then allocates twice, to show that the lowest free way is taken and that a NotPresent line misses presence but is still seen by the raw lookup. Illegal operations are followed by probes and presence tests that would expose a partial write. A hold test with `resp_ready` low catches responses that drop or change early.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_STORE = 2'd1,
    RQ_FETCH = 2'd2
  } rtype_e;

  typedef enum logic [3:0] {
    OP_ACCESS  = 4'd0,
    OP_PRESENT = 4'd1,
    OP_AVAIL   = 4'd2,
    OP_ALLOC   = 4'd3,
    OP_DEALLOC = 4'd4,
    OP_PROBE   = 4'd5,
    OP_LOCK    = 4'd6,
    OP_UNLOCK  = 4'd7,
    OP_TESTLK  = 4'd8,
    OP_SETMRU  = 4'd9,
    OP_SETPERM = 4'd10,
    OP_RAWLOOK = 4'd11
  } op_e;

endpackage

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  // age 0 = most recent, WAYS-1 = least recent; ages stay a permutation
  logic [WAY_W-1:0] age_q [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (age_q[i] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(i);
  end
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tags  [WAYS],
  input  logic              valid [WAYS],
  input  perm_e             perm  [WAYS],
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic              raw_hit,
  output logic [WAY_W-1:0]  raw_way,
  output logic              free_any,
  output logic [WAY_W-1:0]  free_way,
  output logic              same_any
);
  // descending scan so the lowest-numbered way wins each search
  always_comb begin
    hit = 1'b0;      hit_way  = '0;
    raw_hit = 1'b0;  raw_way  = '0;
    free_any = 1'b0; free_way = '0;
    same_any = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (valid[i] && tags[i] == addr) begin
        raw_hit = 1'b1; raw_way = WAY_W'(i); same_any = 1'b1;
        if (perm[i] != PERM_NP) begin
          hit = 1'b1; hit_way = WAY_W'(i);
        end
      end
      if (!valid[i] || perm[i] == PERM_NP) begin
        free_any = 1'b1; free_way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int START_BIT = 4,
  parameter int NUM_SETS  = 4,
  parameter int WAYS      = 4,
  parameter int CTX_W     = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        req_perm,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [1:0]        resp_perm,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              resp_err
);
  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  logic [ADDR_W-1:0] tag_q   [NUM_SETS][WAYS];
  logic              valid_q [NUM_SETS][WAYS];
  perm_e             perm_q  [NUM_SETS][WAYS];
  logic [CTX_W-1:0]  lock_q  [NUM_SETS][WAYS];

  logic [SET_W-1:0]  set_idx;
  logic              accept;
  logic [ADDR_W-1:0] cur_tag   [WAYS];
  logic              cur_valid [WAYS];
  perm_e             cur_perm  [WAYS];
  logic [CTX_W-1:0]  cur_lock  [WAYS];

  logic              m_hit, m_raw, m_free, m_same;
  logic [WAY_W-1:0]  m_way, m_raw_way, m_free_way;
  logic [WAY_W-1:0]  victim [NUM_SETS];
  logic [WAY_W-1:0]  cur_victim;

  logic              nx_hit, nx_err, do_touch;
  logic [WAY_W-1:0]  nx_way, touch_way;
  perm_e             nx_perm;
  logic [ADDR_W-1:0] nx_addr;

  assign set_idx   = req_addr[START_BIT +: SET_W];
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cur_tag[w]   = tag_q[set_idx][w];
      cur_valid[w] = valid_q[set_idx][w];
      cur_perm[w]  = perm_q[set_idx][w];
      cur_lock[w]  = lock_q[set_idx][w];
    end
    cur_victim = victim[set_idx];
  end

  tagdir_match #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_match (
    .addr(req_addr), .tags(cur_tag), .valid(cur_valid), .perm(cur_perm),
    .hit(m_hit), .hit_way(m_way), .raw_hit(m_raw), .raw_way(m_raw_way),
    .free_any(m_free), .free_way(m_free_way), .same_any(m_same)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_lru
    tagdir_lru #(.WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .touch_en(accept && do_touch && set_idx == SET_W'(s)),
      .touch_way(touch_way), .victim_way(victim[s])
    );
  end

  always_comb begin
    nx_hit = 1'b0; nx_err = 1'b0; nx_way = m_way; nx_addr = '0;
    nx_perm = m_hit ? cur_perm[m_way] : PERM_NP;
    do_touch = 1'b0; touch_way = m_way;
    case (req_op)
      OP_ACCESS: begin
        nx_hit = m_hit && (cur_perm[m_way] == PERM_RW ||
                 (cur_perm[m_way] == PERM_RO && req_type != RQ_STORE));
        do_touch = m_hit;
      end
      OP_PRESENT: nx_hit = m_hit;
      OP_AVAIL: begin nx_hit = m_free || m_same; nx_way = m_free_way; end
      OP_ALLOC: begin
        nx_err = m_hit || !m_free;
        nx_hit = 1'b1; nx_way = m_free_way; nx_perm = PERM_INV;
        do_touch = !nx_err; touch_way = m_free_way;
      end
      OP_DEALLOC, OP_LOCK, OP_UNLOCK: begin nx_err = !m_hit; nx_hit = m_hit; end
      OP_PROBE: begin
        nx_err = m_free || m_same; nx_hit = 1'b1;
        nx_way = cur_victim; nx_addr = cur_tag[cur_victim];
        nx_perm = cur_perm[cur_victim];
      end
      OP_TESTLK: begin nx_err = !m_hit; nx_hit = cur_lock[m_way] == req_ctx; end
      OP_SETMRU: begin nx_hit = m_hit; do_touch = m_hit; end
      OP_SETPERM: begin
        nx_err = !m_hit; nx_hit = m_hit; nx_perm = perm_e'(req_perm);
      end
      OP_RAWLOOK: begin
        nx_hit = m_raw; nx_way = m_raw_way;
        nx_perm = m_raw ? cur_perm[m_raw_way] : PERM_NP;
      end
      default: nx_err = 1'b1;
    endcase
    if (nx_err) begin
      nx_hit = 1'b0; do_touch = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]   <= '0;
          valid_q[s][w] <= 1'b0;
          perm_q[s][w]  <= PERM_NP;
          lock_q[s][w]  <= NO_OWNER;
        end
    end else if (accept && !nx_err) begin
      case (req_op)
        OP_ALLOC: begin
          tag_q[set_idx][m_free_way]   <= req_addr;
          valid_q[set_idx][m_free_way] <= 1'b1;
          perm_q[set_idx][m_free_way]  <= PERM_INV;
          lock_q[set_idx][m_free_way]  <= NO_OWNER;
        end
        OP_DEALLOC: begin
          valid_q[set_idx][m_way] <= 1'b0;
          perm_q[set_idx][m_way]  <= PERM_NP;
          lock_q[set_idx][m_way]  <= NO_OWNER;
        end
        OP_LOCK:    lock_q[set_idx][m_way] <= req_ctx;
        OP_UNLOCK:  lock_q[set_idx][m_way] <= NO_OWNER;
        OP_SETPERM: perm_q[set_idx][m_way] <= perm_e'(req_perm);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_way <= '0;
      resp_perm <= '0; resp_addr <= '0; resp_err <= 1'b0;
    end else if (accept) begin
      resp_valid <= 1'b1; resp_hit <= nx_hit; resp_way <= nx_way;
      resp_perm <= nx_perm; resp_addr <= nx_addr; resp_err <= nx_err;
    end else if (resp_ready) begin
      resp_valid <= 1'b0; resp_err <= 1'b0;
    end
  end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_hit,
  input logic [WAY_W-1:0]  resp_way,
  input logic [1:0]        resp_perm,
  input logic [ADDR_W-1:0] resp_addr,
  input logic              resp_err
);
  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  // R2
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) &&
      $stable(resp_way) && $stable(resp_perm) && $stable(resp_addr) &&
      $stable(resp_err));

  // R13
  err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> !resp_hit);

  // R13
  err_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);
endmodule

bind tagdir_top tagdir_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
  .resp_way(resp_way), .resp_perm(resp_perm), .resp_addr(resp_addr),
  .resp_err(resp_err)
);

// File: tb/tagdir_top_tb.sv
`timescale 1ns/1ps
module tagdir_top_tb;
  localparam logic [3:0] ACC = 0, PRES = 1, AVL = 2, ALC = 3, DEAL = 4,
    PROBE = 5, LCK = 6, ULCK = 7, TLCK = 8, MRU = 9, SPERM = 10, RAW = 11;
  localparam logic [1:0] LD = 0, ST = 1, IF = 2;
  localparam logic [1:0] NP = 0, INV = 1, RO = 2, RW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, resp_ready = 1;
  logic [3:0] req_op = 0;
  logic [1:0] req_type = 0, req_perm = 0;
  logic [15:0] req_addr = 0;
  logic [3:0] req_ctx = 0;
  logic req_ready, resp_valid, resp_hit, resp_err;
  logic [1:0] resp_way, resp_perm;
  logic [15:0] resp_addr;

  int total = 0, bad = 0;
  logic r_hit, r_err;
  logic [1:0] r_way, r_perm;
  logic [15:0] r_addr;

  always #2.5 clk = ~clk;

  tagdir_top u_dut (.*);

  function automatic logic [15:0] mk(input int tg, input int st);
    return 16'((tg << 6) | (st << 4));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] o, input logic [15:0] a,
                    input logic [1:0] ty = 0, input logic [3:0] cx = 0,
                    input logic [1:0] pm = 0);
    @(negedge clk);
    req_valid = 1; req_op = o; req_addr = a; req_type = ty;
    req_ctx = cx; req_perm = pm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    r_hit = resp_hit; r_err = resp_err; r_way = resp_way;
    r_perm = resp_perm; r_addr = resp_addr;
  endtask

  task automatic t_reset();
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    op(PRES, mk(1, 1)); chk("R1 present", r_hit, 0);
    op(AVL, mk(1, 1));  chk("R1 avail", r_hit, 1);
  endtask

  task automatic t_alloc_perm();
    logic [15:0] a = mk(1, 1);
    op(ALC, a); chk("R8 alloc way", r_way, 0); chk("R8 alloc perm", r_perm, INV);
    chk("R8 alloc ok", r_hit, 1);
    op(PRES, a); chk("R4 present Invalid", r_hit, 1);
    op(ACC, a, LD); chk("R5 load on Invalid", r_hit, 0);
    op(SPERM, a, 0, 0, RO); chk("R12 setperm", r_hit, 1);
    op(ACC, a, LD); chk("R5 load RO", r_hit, 1); chk("R5 perm RO", r_perm, RO);
    op(ACC, a, IF); chk("R5 fetch RO", r_hit, 1);
    op(ACC, a, ST); chk("R5 store RO", r_hit, 0);
    op(SPERM, a, 0, 0, RW);
    op(ACC, a, ST); chk("R5 store RW", r_hit, 1);
    op(ALC, a); chk("R13 dup alloc err", r_err, 1); chk("R13 dup alloc hit", r_hit, 0);
  endtask

  task automatic t_lru();
    op(ALC, mk(2, 1)); chk("R8 way1", r_way, 1);
    op(ALC, mk(3, 1)); chk("R8 way2", r_way, 2);
    op(ALC, mk(4, 1)); chk("R8 way3", r_way, 3);
    op(AVL, mk(5, 1)); chk("R7 full", r_hit, 0);
    op(ALC, mk(5, 1)); chk("R13 full alloc", r_err, 1);
    op(PROBE, mk(5, 1)); chk("R10 victim A", r_addr, mk(1, 1));
    chk("R13 no change after err", r_way, 0);
    op(ACC, mk(1, 1), LD);
    op(PROBE, mk(5, 1)); chk("R10 victim B", r_addr, mk(2, 1)); chk("R10 way", r_way, 1);
    op(ACC, mk(2, 1), ST); chk("R6 denied store", r_hit, 0);
    op(PROBE, mk(5, 1)); chk("R6 touch on denied", r_addr, mk(3, 1));
    op(MRU, mk(3, 1)); chk("R12 mru hit", r_hit, 1);
    op(MRU, mk(5, 1)); chk("R12 mru miss", r_hit, 0);
    op(PROBE, mk(5, 1)); chk("R12 victim D", r_addr, mk(4, 1));
  endtask

  task automatic t_refill();
    op(SPERM, mk(4, 1), 0, 0, NP);
    op(PRES, mk(4, 1)); chk("R4 NP misses", r_hit, 0);
    op(RAW, mk(4, 1)); chk("R4 raw hit", r_hit, 1); chk("R4 raw way", r_way, 3);
    chk("R4 raw perm", r_perm, NP);
    op(AVL, mk(7, 1)); chk("R7 NP way free", r_hit, 1);
    op(DEAL, mk(2, 1)); chk("R9 dealloc", r_err, 0);
    op(ALC, mk(5, 1)); chk("R8 lowest free", r_way, 1);
    op(ALC, mk(6, 1)); chk("R8 NP way reused", r_way, 3);
    op(AVL, mk(1, 1)); chk("R7 same addr avail", r_hit, 1);
    op(AVL, mk(7, 1)); chk("R7 full again", r_hit, 0);
    op(DEAL, mk(7, 1)); chk("R13 dealloc absent", r_err, 1);
    op(DEAL, mk(5, 1)); chk("R9 dealloc E", r_hit, 1);
    op(PRES, mk(5, 1)); chk("R9 gone", r_hit, 0);
  endtask

  task automatic t_locks();
    op(LCK, mk(1, 1), 0, 5); chk("R11 lock", r_err, 0);
    op(TLCK, mk(1, 1), 0, 5); chk("R11 owner", r_hit, 1);
    op(TLCK, mk(1, 1), 0, 6); chk("R11 other ctx", r_hit, 0);
    op(ULCK, mk(1, 1));
    op(TLCK, mk(1, 1), 0, 5); chk("R11 cleared", r_hit, 0);
    op(TLCK, mk(1, 1), 0, 15); chk("R11 no-owner", r_hit, 1);
    op(TLCK, mk(6, 1), 0, 15); chk("R8 fresh lock", r_hit, 1);
    op(LCK, mk(7, 1), 0, 3); chk("R13 lock absent", r_err, 1);
    op(TLCK, mk(7, 1), 0, 15); chk("R13 testlock absent", r_hit, 0);
    op(4'd13, mk(1, 1)); chk("R13 bad opcode", r_err, 1);
  endtask

  task automatic t_index();
    op(PRES, mk(1, 2)); chk("R3 other set", r_hit, 0);
    op(PROBE, mk(1, 2)); chk("R13 probe with room", r_err, 1);
    op(ALC, mk(1, 2)); chk("R3 alloc set2", r_way, 0); chk("R3 no err", r_err, 0);
    op(PRES, mk(1, 1)); chk("R3 set1 intact", r_hit, 1); chk("R3 way", r_way, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    resp_ready = 0; req_valid = 1; req_op = PRES; req_addr = mk(1, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R2 resp valid", resp_valid, 1);
    chk("R2 ready low", req_ready, 0);
    repeat (2) @(negedge clk);
    chk("R2 held", resp_valid, 1); chk("R2 held hit", resp_hit, 1);
    resp_ready = 1;
    @(negedge clk);
    chk("R2 consumed", resp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc_perm();
    t_lru();
    t_refill();
    t_locks();
    t_index();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule